// File: doc/BRIEF.md
# Packet-Boundary Byte Budget Limiter

This block caps the number of bytes one Ethernet port may move in one direction during a fixed time window. A MAC feeds it three strobes: one for the first cycle of a frame, one for every byte, one for the last cycle of a frame. An 8-bit rate code sets the budget. Each unit of the code allows 512 bytes per window. The window lasts 10 ms on a 100 Mbps link and 100 ms on a 10 Mbps link, and each length is given in clock cycles as a parameter.

Once the count for the window reaches the budget, a frame that is already open runs to its end. The block then raises `throttle_o` for the rest of the window, so the MAC starts no new frame and flow-control logic can hold off the link partner. The same instance serves ingress or egress, because it only counts strobes.

The rate code and the speed flag are sampled only at window boundaries. Any change therefore applies to the whole of the next window.

Top module: `byte_rate_limiter`

## Requirements
- R1: The budget is the active rate code times 512 bytes. When the byte count of the current window is at or above the budget and no frame is open, `throttle_o` is high in the cycle after the byte that reached the budget.
- R2: A window lasts `WIN_FAST` cycles while the active speed flag is 1 (100 Mbps) and `WIN_SLOW` cycles while it is 0 (10 Mbps).
- R3: While a frame is open, `throttle_o` stays low even past the budget. A frame opens on `pkt_start_i` and closes on `pkt_end_i`. If the count is at or above the budget, `throttle_o` rises in the cycle after `pkt_end_i`.
- R4: Once high, `throttle_o` stays high until the window ends. A `pkt_start_i` that arrives while `throttle_o` is high opens no frame.
- R5: At each window end, the byte count clears and `throttle_o` is low in the first cycle of the new window. A byte strobed in the last cycle of a window counts toward the new window.
- R6: An active rate code of 0 turns limiting off, so `throttle_o` stays low whatever the traffic.
- R7: `rate_i` and `speed_100_i` are sampled only in the last cycle of a window. A change made mid-window has no effect until the following window.
- R8: After reset, the timer is at the start of a window, the active rate code is 0, the active speed flag is 1 and `throttle_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rate_i | input | RATE_W | Requested rate code, in units of 512 bytes per window; 0 turns limiting off |
| speed_100_i | input | 1 | 1 for a 100 Mbps link, 0 for a 10 Mbps link |
| pkt_start_i | input | 1 | Pulse in the first cycle of a frame |
| byte_vld_i | input | 1 | One byte transferred in this cycle |
| pkt_end_i | input | 1 | Pulse in the last cycle of a frame |
| throttle_o | output | 1 | High while new frames must be held off |

## Verification
Every state change goes through a single register stage, and `throttle_o` is decoded straight from those registers. Each response is therefore due exactly one cycle after the strobe that causes it:
- the byte that reaches the budget raises `throttle_o` one cycle later;
- the end-of-frame strobe releases a held throttle one cycle later;
- the last cycle of a window clears `throttle_o` one cycle later.

A behavioural model in the bench applies the same rules to the inputs sampled at each rising edge. The bench compares `throttle_o` with the model at every falling edge. The directed checks also sample at falling edges, counted from the strobe that triggers them. One of them measures the full span of a 10 Mbps window from its first cycle to the release of the throttle.

// File: rtl/brl_pkg.sv
package brl_pkg;
  parameter int unsigned RATE_W = 8;
  parameter int unsigned UNIT_BYTES = 512;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              fast;
  } brl_cfg_t;
endpackage

// File: rtl/brl_window_timer.sv
module brl_window_timer #(
  parameter int unsigned WIN_FAST = 250000,
  parameter int unsigned WIN_SLOW = 2500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  output logic win_end_o
);
  localparam int unsigned WIN_MAX = (WIN_FAST > WIN_SLOW) ? WIN_FAST : WIN_SLOW;
  localparam int unsigned TMR_W   = $clog2(WIN_MAX + 1);

  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] last_cyc;

  assign last_cyc  = fast_i ? TMR_W'(WIN_FAST - 1) : TMR_W'(WIN_SLOW - 1);
  assign win_end_o = (tmr_q >= last_cyc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tmr_q <= '0;
    else if (win_end_o) tmr_q <= '0;
    else                tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/brl_cfg_shadow.sv
module brl_cfg_shadow
  import brl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              fast_i,
  output brl_cfg_t          cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o.rate <= '0;
      cfg_o.fast <= 1'b1;
    end else if (load_i) begin
      cfg_o.rate <= rate_i;
      cfg_o.fast <= fast_i;
    end
  end
endmodule

// File: rtl/brl_byte_meter.sv
module brl_byte_meter #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             vld_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (clear_i)  cnt_o <= CNT_W'(vld_i);
    else if (!(&cnt_o)) cnt_o <= cnt_o + CNT_W'(vld_i);
  end
endmodule

// File: rtl/brl_pkt_gate.sv
module brl_pkt_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  input  logic block_i,
  output logic open_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    open_o <= 1'b0;
    else if (end_i)                 open_o <= 1'b0;
    else if (start_i && !block_i)   open_o <= 1'b1;
  end
endmodule

// File: rtl/byte_rate_limiter.sv
module byte_rate_limiter
  import brl_pkg::*;
#(
  parameter int unsigned WIN_FAST = 250000,
  parameter int unsigned WIN_SLOW = 2500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              speed_100_i,
  input  logic              pkt_start_i,
  input  logic              byte_vld_i,
  input  logic              pkt_end_i,
  output logic              throttle_o
);
  localparam int unsigned UNIT_LG = $clog2(UNIT_BYTES);
  localparam int unsigned CNT_W   = RATE_W + UNIT_LG + 1;

  brl_cfg_t         cfg;
  logic             win_end;
  logic [CNT_W-1:0] byte_cnt;
  logic [CNT_W-1:0] budget;
  logic             pkt_open;
  logic             spent;

  brl_window_timer #(.WIN_FAST(WIN_FAST), .WIN_SLOW(WIN_SLOW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .fast_i(cfg.fast), .win_end_o(win_end)
  );

  brl_cfg_shadow u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(win_end),
    .rate_i(rate_i), .fast_i(speed_100_i), .cfg_o(cfg)
  );

  brl_byte_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(win_end),
    .vld_i(byte_vld_i), .cnt_o(byte_cnt)
  );

  brl_pkt_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(pkt_start_i),
    .end_i(pkt_end_i), .block_i(throttle_o), .open_o(pkt_open)
  );

  assign budget     = CNT_W'(cfg.rate) << UNIT_LG;
  assign spent      = (cfg.rate != '0) && (byte_cnt >= budget);
  assign throttle_o = spent && !pkt_open;
endmodule

// File: rtl/byte_rate_limiter_chk.sv
module byte_rate_limiter_chk
  import brl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              throttle_o,
  input logic              win_end,
  input logic              pkt_open,
  input logic [RATE_W-1:0] cfg_rate,
  input logic              cfg_fast
);
  // R3
  open_blocks_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_open |-> !throttle_o);

  // R5
  boundary_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end |=> !throttle_o);

  // R6
  rate_zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rate == '0) |-> !throttle_o);

  // R4
  thr_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (throttle_o && !win_end) |=> throttle_o);

  // R7
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> ($stable(cfg_rate) && $stable(cfg_fast)));
endmodule

bind byte_rate_limiter byte_rate_limiter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .throttle_o(throttle_o), .win_end(win_end),
  .pkt_open(pkt_open), .cfg_rate(cfg.rate), .cfg_fast(cfg.fast)
);

// File: tb/byte_rate_limiter_bench.sv
module byte_rate_limiter_bench;
  localparam int F_LEN = 1200;
  localparam int S_LEN = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rate = '0;
  logic       spd = 1'b1;
  logic       st = 1'b0, vld = 1'b0, en = 1'b0;
  logic       thr;

  int vectors = 0, errors = 0, cyc = 0;
  string phase = "R8";

  // reference model state
  int m_tmr = 0, m_bytes = 0, m_rate = 0;
  bit m_fast = 1, m_open = 0;

  always #10 clk = ~clk;

  byte_rate_limiter #(.WIN_FAST(F_LEN), .WIN_SLOW(S_LEN)) u_byte_rate_limiter (
    .clk_i(clk), .rst_ni(rst_n), .rate_i(rate), .speed_100_i(spd),
    .pkt_start_i(st), .byte_vld_i(vld), .pkt_end_i(en), .throttle_o(thr)
  );

  function automatic bit m_thr();
    return (m_rate != 0) && (m_bytes >= m_rate * 512) && !m_open;
  endfunction

  function automatic int m_len();
    return m_fast ? F_LEN : S_LEN;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tmr = 0; m_bytes = 0; m_rate = 0; m_fast = 1; m_open = 0;
    end else begin
      bit blk;
      blk = m_thr();
      if (en) m_open = 0;
      else if (st && !blk) m_open = 1;
      if (m_tmr == m_len() - 1) begin
        m_tmr = 0; m_bytes = vld ? 1 : 0; m_rate = rate; m_fast = spd;
      end else begin
        m_tmr++; m_bytes += vld ? 1 : 0;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      vectors++;
      if (thr !== m_thr()) begin
        errors++;
        $display("FAIL %s: throttle_o act=%b exp=%b at cycle %0d", phase, thr, m_thr(), cyc);
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string req);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int n);
    for (int i = 0; i < n; i++) begin
      st = (i == 0); vld = 1'b1; en = (i == n - 1);
      @(negedge clk);
    end
    st = 1'b0; vld = 1'b0; en = 1'b0;
  endtask

  task automatic loose_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      vld = 1'b1;
      @(negedge clk);
    end
    vld = 1'b0;
  endtask

  task automatic wait_boundary(input bit with_byte);
    while (m_tmr != m_len() - 1) @(negedge clk);
    vld = with_byte;
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    int span;
    repeat (3) @(negedge clk);
    chk(thr, 1'b0, "R8 reset throttle");
    rst_n = 1'b1;
    @(negedge clk);
    chk(thr, 1'b0, "R8 after reset");

    phase = "R7";
    rate = 8'd1; spd = 1'b1;
    send_pkt(700);
    chk(thr, 1'b0, "R7 first window keeps reset rate 0");

    wait_boundary(1'b0);
    phase = "R3";
    send_pkt(600);
    chk(thr, 1'b1, "R3 throttle after frame end past budget");
    chk(thr, 1'b1, "R1 budget 512 for code 1");

    phase = "R4";
    st = 1'b1; @(negedge clk); st = 1'b0;
    chk(thr, 1'b1, "R4 start while throttled ignored");
    rate = 8'd0;
    repeat (5) @(negedge clk);
    chk(thr, 1'b1, "R7 rate change mid-window not applied");

    phase = "R5";
    wait_boundary(1'b1);
    chk(thr, 1'b0, "R5 throttle clear at new window");

    phase = "R6";
    loose_bytes(700);
    chk(thr, 1'b0, "R6 rate 0 never throttles");

    phase = "R5";
    rate = 8'd1;
    wait_boundary(1'b1);
    loose_bytes(510);
    @(negedge clk);
    chk(thr, 1'b0, "R5 511 bytes under budget");
    loose_bytes(1);
    chk(thr, 1'b1, "R5 boundary byte counted in new window");

    phase = "R1";
    rate = 8'd2;
    wait_boundary(1'b0);
    loose_bytes(1023);
    chk(thr, 1'b0, "R1 code 2 one byte short");
    loose_bytes(1);
    chk(thr, 1'b1, "R1 code 2 budget 1024 reached");

    phase = "R2";
    rate = 8'd1; spd = 1'b0;
    wait_boundary(1'b0);
    span = 0;
    loose_bytes(512);
    span += 512;
    chk(thr, 1'b1, "R2 slow window throttled");
    while (thr === 1'b1 && span < 10000) begin
      @(negedge clk);
      span++;
    end
    vectors++;
    if (span != S_LEN) begin
      errors++;
      $display("FAIL R2: slow window span act=%0d exp=%0d", span, S_LEN);
    end

    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule